// File: doc/BRIEF.md
# Third-Order Cascaded Delta-Sigma Division Word Generator

This block drives the division ratio of a fractional-N frequency divider. Once per reference cycle it takes an integer base ratio and an N-bit fractional word and produces an integer offset. The long-run average of the offset equals the fractional word divided by 2^N. Three first-order accumulators are chained so that each one integrates the residue of the one before it. A cancellation network then combines their overflow bits so that the quantization error of the first two stages is removed, and the error that remains is shaped towards high frequencies.

An optional lengthening mode forces the lowest bit of the first stage's addend to one. The first accumulator then always steps by an odd amount, so it visits every one of its 2^N states. This stretches the output period to its maximum for any input word, which breaks up short repeating patterns and the spurs they cause.

The registered sum of base ratio and offset feeds a delay line with eight taps. Each tap goes to its own parallel divider path, and the summed outputs of those paths form an FIR filter on the shaped noise. The block has no state machine. Every stage advances on each clock, and a synchronous active-high reset clears all state.

Top module: `mash3_divword`

## Requirements
- R1: A synchronous reset, sampled high on a clock edge, clears all three accumulators, the cancellation history, `offset`, `ratio_word` and every tap of `tap_bus` to zero.
- R2: `offset` is a 4-bit two's-complement value that always lies in the range -3 to +4.
- R3: Lengthening is off when `lengthen_en` = 0. In that case, over any run of L cycles that starts at reset release, the sum of the `offset` values is within 3 of L*F/2^N, where F is `frac_word`.
- R4: The offset of each cycle is y = c1 + (c2 - c2') + (c3 - 2*c3' + c3''), where ck is the overflow of stage k and a prime marks a value one cycle older. With F = 2^(N-1) and lengthening off, this gives the repeating sequence 0, +2, -1, +1, starting at the first edge after reset release.
- R5: With `lengthen_en` = 1, bit 0 of the first stage's addend is forced to 1. With F = 0 the output is therefore not constant, and the R3 bound holds with F replaced by F|1.
- R6: With `lengthen_en` = 0 and F = 0, `offset` stays 0 on every cycle.
- R7: `ratio_word` is registered on the same edge as `offset` and equals the `int_word` sampled on that edge plus the sign-extended offset. It is INT_W+1 bits wide.
- R8: Bits [k*RW +: RW] of `tap_bus` (RW = INT_W+1) hold `ratio_word` delayed by k cycles, for k = 0..7. Tap 0 is `ratio_word` itself.
- R9: Every accumulator wraps modulo 2^N. F = 2^N-1 runs indefinitely and meets the R3 bound.
- R10: For an odd F, `lengthen_en` has no effect: the offset sequence is identical with it set or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| int_word | input | INT_W | Integer part of the division ratio |
| frac_word | input | ACC_W | Fractional word F, weight 2^-ACC_W |
| lengthen_en | input | 1 | Forces the first addend's LSB to 1 |
| offset | output | 4 | Signed offset, -3..+4 |
| ratio_word | output | INT_W+1 | int_word plus offset, registered |
| tap_bus | output | NTAPS*(INT_W+1) | Delayed copies of ratio_word, tap k at k cycles |

## Verification
The bench builds the block with ACC_W = 8, INT_W = 9 and NTAPS = 8. The narrow accumulator makes the full state cycle only 256 steps long. Each 1024-cycle window therefore spans several complete periods, so the mean bound of R3 holds tightly, and the exact short pattern for F = 128 can be predicted by hand. With nine integer bits the base ratios cover the 32 to 504 range of the divider. All eight taps are checked against a history of earlier ratio samples.

// File: rtl/mash_pkg.sv
package mash_pkg;
    localparam int OFS_W  = 4;
    localparam int STAGES = 3;
    typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/mash_accum.sv
module mash_accum #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] residue,
    output logic             carry
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum_w;

    always_comb begin
        sum_w   = {1'b0, acc_q} + {1'b0, addend};
        residue = sum_w[ACC_W-1:0];
        carry   = sum_w[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= residue;
    end

    // R1
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> acc_q == '0);

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        carry |-> residue < addend);
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
    import mash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] cy,
    output ofs_t              y
);
    logic c2_d, c3_d, c3_dd;

    always_ff @(posedge clk) begin
        if (rst) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else begin
            c2_d  <= cy[1];
            c3_d  <= cy[2];
            c3_dd <= c3_d;
        end
    end

    always_comb begin
        y = ofs_t'({{(OFS_W-1){1'b0}}, cy[0]})
          + ofs_t'({{(OFS_W-1){1'b0}}, cy[1]})
          - ofs_t'({{(OFS_W-1){1'b0}}, c2_d})
          + ofs_t'({{(OFS_W-1){1'b0}}, cy[2]})
          - ofs_t'({{(OFS_W-2){1'b0}}, c3_d, 1'b0})
          + ofs_t'({{(OFS_W-1){1'b0}}, c3_dd});
    end
endmodule

// File: rtl/mash_tapline.sv
module mash_tapline #(
    parameter int RW    = 10,
    parameter int NTAPS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RW-1:0]       din,
    output logic [NTAPS*RW-1:0] tap_bus
);
    logic [RW-1:0] dly [1:NTAPS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k < NTAPS; k++) dly[k] <= '0;
        end else begin
            dly[1] <= din;
            for (int k = 2; k < NTAPS; k++) dly[k] <= dly[k-1];
        end
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        if (k == 0) begin : g_head
            assign tap_bus[RW-1:0] = din;
        end else begin : g_body
            assign tap_bus[k*RW +: RW] = dly[k];
            if (k == 1) begin : g_first
                // R8
                tap_shift_chk: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> dly[1] == $past(din));
            end else begin : g_rest
                // R8
                tap_shift_chk: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> dly[k] == $past(dly[k-1]));
            end
        end
    end
endmodule

// File: rtl/mash3_divword.sv
module mash3_divword
    import mash_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int INT_W = 9,
    parameter int NTAPS = 8,
    localparam int RW   = INT_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [INT_W-1:0]           int_word,
    input  logic [ACC_W-1:0]           frac_word,
    input  logic                       lengthen_en,
    output logic signed [OFS_W-1:0]    offset,
    output logic [RW-1:0]              ratio_word,
    output logic [NTAPS*RW-1:0]        tap_bus
);
    logic [ACC_W-1:0]  link [0:STAGES];
    logic [STAGES-1:0] cy;
    ofs_t              y_w;
    ofs_t              offset_q;
    logic [RW-1:0]     ratio_q;
    logic [RW-1:0]     ratio_nx;

    assign link[0] = {frac_word[ACC_W-1:1], frac_word[0] | lengthen_en};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        mash_accum #(.ACC_W(ACC_W)) u_acc (
            .clk     (clk),
            .rst     (rst),
            .addend  (link[g]),
            .residue (link[g+1]),
            .carry   (cy[g])
        );
    end

    mash_cancel u_cancel (
        .clk (clk),
        .rst (rst),
        .cy  (cy),
        .y   (y_w)
    );

    always_comb ratio_nx = RW'(int_word) + {{(RW-OFS_W){y_w[OFS_W-1]}}, y_w};

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            ratio_q  <= '0;
        end else begin
            offset_q <= y_w;
            ratio_q  <= ratio_nx;
        end
    end

    assign offset     = offset_q;
    assign ratio_word = ratio_q;

    mash_tapline #(.RW(RW), .NTAPS(NTAPS)) u_taps (
        .clk     (clk),
        .rst     (rst),
        .din     (ratio_q),
        .tap_bus (tap_bus)
    );

    // R2
    offset_range_chk: assert property (@(posedge clk) disable iff (rst)
        (offset_q >= -4'sd3) && (offset_q <= 4'sd4));

    // R7
    ratio_sum_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ratio_q == RW'($past(int_word))
                                   + {{(RW-OFS_W){offset_q[OFS_W-1]}}, offset_q});
endmodule

// File: tb/sim_mash3_divword.sv
module sim_mash3_divword;
    localparam int ACC_W = 8;
    localparam int INT_W = 9;
    localparam int NTAPS = 8;
    localparam int RW    = INT_W + 1;
    localparam int LWIN  = 1024;
    localparam int NVEC  = 8;

    localparam int V_FRAC [NVEC] = '{128, 1, 255, 85, 64, 0, 170, 3};
    localparam int V_LEN  [NVEC] = '{0,   0, 0,   0,  1,  1, 1,   0};
    localparam int V_INT  [NVEC] = '{200, 32, 504, 64, 100, 300, 77, 40};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [INT_W-1:0] int_word = '0;
    logic [ACC_W-1:0] frac_word = '0;
    logic lengthen_en = 1'b0;
    logic signed [3:0] offset;
    logic [RW-1:0] ratio_word;
    logic [NTAPS*RW-1:0] tap_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int hist [NTAPS];
    int seq_a [256];

    always #2 clk = ~clk;

    mash3_divword #(.ACC_W(ACC_W), .INT_W(INT_W), .NTAPS(NTAPS)) u0 (
        .clk(clk), .rst(rst), .int_word(int_word), .frac_word(frac_word),
        .lengthen_en(lengthen_en), .offset(offset), .ratio_word(ratio_word),
        .tap_bus(tap_bus)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NTAPS; k++) hist[k] = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int sum, expv, o, bad_rng, bad_rat, bad_tap, nz, diff;

        // R1: state after reset
        do_reset();
        chk(offset == 0, "R1 offset", offset, 0);
        chk(ratio_word == 0, "R1 ratio", ratio_word, 0);
        chk(tap_bus == '0, "R1 taps", (tap_bus == '0) ? 0 : 1, 0);

        // Table walk: R3, R5, R9 mean; R2 range; R7 ratio; R8 taps
        for (int v = 0; v < NVEC; v++) begin
            frac_word   = V_FRAC[v][ACC_W-1:0];
            lengthen_en = V_LEN[v][0];
            int_word    = V_INT[v][INT_W-1:0];
            do_reset();
            sum = 0; bad_rng = 0; bad_rat = 0; bad_tap = 0;
            for (int n = 0; n < LWIN; n++) begin
                @(negedge clk);
                o = int'(offset);
                sum += o;
                if (o < -3 || o > 4) bad_rng++;
                if (int'(ratio_word) != V_INT[v] + o) bad_rat++;
                for (int k = NTAPS-1; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = int'(ratio_word);
                for (int k = 0; k < NTAPS; k++)
                    if (int'(tap_bus[k*RW +: RW]) != hist[k]) bad_tap++;
            end
            expv = (LWIN * (V_FRAC[v] | V_LEN[v])) / 256;
            diff = sum - expv;
            chk(diff >= -3 && diff <= 3, (V_LEN[v] != 0) ? "R5 mean" :
                (V_FRAC[v] == 255 ? "R9 mean" : "R3 mean"), sum, expv);
            chk(bad_rng == 0, "R2 range", bad_rng, 0);
            chk(bad_rat == 0, "R7 ratio", bad_rat, 0);
            chk(bad_tap == 0, "R8 taps", bad_tap, 0);
        end

        // R4: exact pattern 0,2,-1,1 for F = 128
        frac_word = 8'd128; lengthen_en = 1'b0; int_word = 9'd100;
        do_reset();
        for (int n = 0; n < 12; n++) begin
            int pat [4] = '{0, 2, -1, 1};
            @(negedge clk);
            chk(int'(offset) == pat[n % 4], "R4 pattern", int'(offset), pat[n % 4]);
        end

        // R1: reset mid-run clears outputs and taps
        rst = 1'b1;
        @(negedge clk);
        chk(offset == 0 && ratio_word == 0 && tap_bus == '0, "R1 midrun",
            int'(ratio_word), 0);
        rst = 1'b0;

        // R6: F = 0, lengthening off gives constant zero
        frac_word = '0; lengthen_en = 1'b0;
        do_reset();
        nz = 0;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (offset != 0) nz++;
        end
        chk(nz == 0, "R6 zero", nz, 0);

        // R5: F = 0, lengthening on gives activity
        lengthen_en = 1'b1;
        do_reset();
        nz = 0;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (offset != 0) nz++;
        end
        chk(nz > 0, "R5 active", nz, 1);

        // R10: odd F unaffected by lengthening
        frac_word = 8'd85; lengthen_en = 1'b0;
        do_reset();
        for (int n = 0; n < 256; n++) begin
            @(negedge clk);
            seq_a[n] = int'(offset);
        end
        lengthen_en = 1'b1;
        do_reset();
        nz = 0;
        for (int n = 0; n < 256; n++) begin
            @(negedge clk);
            if (int'(offset) != seq_a[n]) nz++;
        end
        chk(nz == 0, "R10 odd", nz, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule